// File: doc/BRIEF.md
# Floating-Point Compare Condition Code Writer

This block compares two IEEE 754 operands and records the outcome as a 2-bit condition code in a 64-bit floating-point status word. The operands can be single or double precision. The code goes into one of four condition fields, chosen by a 2-bit field index. Field 0 sits low in the word. Fields 1 to 3 sit side by side much higher up, so the four fields are not evenly spaced.

An unordered result means at least one operand is NaN. In that case the block either raises a trap or records the accrued invalid flag. The choice depends on two things:

- the invalid trap-enable bit in the incoming status word;
- whether the compare is the signaling kind, which traps on every unordered result.

The caller presents the current status word with a start strobe. One cycle later the block returns the updated word, a done pulse and, when needed, a trap request.

Top module: `fcmp_ccw`

## Requirements
- R1: The relation code is 0 for equal, 1 for a less than b, 2 for a greater than b and 3 for unordered. It is written into the selected field, which is cleared first. All other condition fields keep their incoming value.
- R2: Field index 0 writes status bits [11:10]. Index 1 writes [33:32], index 2 writes [35:34] and index 3 writes [37:36].
- R3: Positive and negative zero compare equal. An exponent of all ones with a zero fraction is an infinity, not a NaN, and it orders normally. NaN is an all-ones exponent with a non-zero fraction.
- R4: In single precision (`is_double` = 0) only bits [31:0] of each operand are used. Bits [63:32] have no effect on the result.
- R5: This requirement covers an unordered result from the ordinary compare with the trap-enable bit 27 clear. Accrued-invalid bit 9 is set. No trap is requested. Current-invalid bit 4 and the trap-type field [16:14] keep their incoming values.
- R6: This requirement covers an unordered result when bit 27 is set or the compare is signaling. Current-invalid bit 4 is set and the trap-type field [16:14] becomes 1. `trap_req` pulses together with `done`. Bit 9 keeps its incoming value.
- R7: An ordered result, from either compare kind, changes only the selected field and raises no trap. Every status bit outside the selected field, bit 4, bit 9 and bits [16:14] always passes through unchanged.
- R8: `done` and the new `stat_out` appear on the clock edge after the edge that samples `start`. `done` stays high for one cycle per start. `stat_out` holds its value while no start arrives.
- R9: During reset `stat_out` is zero and `done` and `trap_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launches one compare on this edge |
| is_double | input | 1 | 1 selects double precision, 0 selects single precision |
| signaling | input | 1 | 1 selects the compare that always traps on unordered |
| fcc_sel | input | 2 | Index of the condition field to write |
| op_a | input | 64 | First operand; single precision uses the low 32 bits |
| op_b | input | 64 | Second operand; single precision uses the low 32 bits |
| stat_in | input | 64 | Current status word |
| stat_out | output | 64 | Updated status word, registered |
| done | output | 1 | One-cycle pulse when `stat_out` is updated |
| trap_req | output | 1 | Floating-point trap request, valid with `done` |

## Verification
The checker assumes that `stat_in`, `fcc_sel` and `signaling` stay steady from the edge that samples `start` until the result is checked. It compares the result against the `stat_in` value sampled at that start edge.

The bench meets this assumption as follows:

- it changes inputs only on falling edges;
- it keeps a vector's inputs in place until after its `done` cycle;
- it changes `stat_in` with `start` low only in the hold test.

The background status pattern has bits 4 and 9 cleared, so that any write to them shows up.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;

    localparam int STAT_W     = 64;
    localparam int OP_W       = 64;
    localparam int MAG_W      = OP_W - 1;
    localparam int FCC_BASE   = 10;
    localparam int FCC_STRIDE = 2;
    localparam int FCC_FAR    = 22;   // distance of field 1 from field 0
    localparam int NUM_FCC    = 4;
    localparam int SEL_W      = $clog2(NUM_FCC);
    localparam int INV_CUR    = 4;
    localparam int INV_ACC    = 9;
    localparam int INV_TEN    = 27;
    localparam int TT_LSB     = 14;
    localparam int TT_W       = 3;
    localparam logic [TT_W-1:0] TT_IEEE = 3'd1;

    typedef enum logic [1:0] {
        REL_EQ = 2'd0,
        REL_LT = 2'd1,
        REL_GT = 2'd2,
        REL_UN = 2'd3
    } rel_e;

    typedef struct packed {
        logic             sign;
        logic             nan;
        logic [MAG_W-1:0] mag;
    } fop_t;

    function automatic int fcc_lsb(input int idx);
        return (idx == 0) ? FCC_BASE
                          : FCC_BASE + FCC_FAR + FCC_STRIDE * (idx - 1);
    endfunction

endpackage

// File: rtl/fcmp_unpack.sv
module fcmp_unpack
    import fcmp_pkg::*;
(
    input  logic [OP_W-1:0] op,
    input  logic            is_double,
    output fop_t            fo
);
    localparam int SE_W = 8;
    localparam int SF_W = 23;
    localparam int DE_W = 11;
    localparam int DF_W = 52;
    localparam int S_W  = 1 + SE_W + SF_W;

    always_comb begin
        if (is_double) begin
            fo.sign = op[OP_W-1];
            fo.mag  = op[MAG_W-1:0];
            fo.nan  = (&op[DF_W +: DE_W]) && (|op[DF_W-1:0]);
        end else begin
            fo.sign = op[S_W-1];
            fo.mag  = {{(MAG_W-S_W+1){1'b0}}, op[S_W-2:0]};
            fo.nan  = (&op[SF_W +: SE_W]) && (|op[SF_W-1:0]);
        end
    end
endmodule

// File: rtl/fcmp_relate.sv
module fcmp_relate
    import fcmp_pkg::*;
(
    input  fop_t a,
    input  fop_t b,
    output rel_e rel
);
    logic both_zero;
    logic mag_lt;

    assign both_zero = (a.mag == '0) && (b.mag == '0);
    assign mag_lt    = a.mag < b.mag;

    always_comb begin
        if (a.nan || b.nan)
            rel = REL_UN;
        else if (both_zero)
            rel = REL_EQ;
        else if (a.sign != b.sign)
            rel = a.sign ? REL_LT : REL_GT;
        else if (a.mag == b.mag)
            rel = REL_EQ;
        else
            rel = (mag_lt ^ a.sign) ? REL_LT : REL_GT;
    end
endmodule

// File: rtl/fcmp_stat_merge.sv
module fcmp_stat_merge
    import fcmp_pkg::*;
(
    input  logic [STAT_W-1:0] stat_in,
    input  rel_e              rel,
    input  logic [SEL_W-1:0]  fcc_sel,
    input  logic              signaling,
    output logic [STAT_W-1:0] stat_nxt,
    output logic              trap
);
    logic [STAT_W-1:0] with_fcc;
    logic              unord;

    assign unord = (rel == REL_UN);
    assign trap  = unord && (signaling || stat_in[INV_TEN]);

    // Insert the relation code into the one field the index selects.
    always_comb begin
        with_fcc = stat_in;
        for (int i = 0; i < NUM_FCC; i++) begin
            if (fcc_sel == SEL_W'(i))
                with_fcc[fcc_lsb(i) +: 2] = rel;
        end
    end

    always_comb begin
        stat_nxt = with_fcc;
        if (trap) begin
            stat_nxt[INV_CUR]           = 1'b1;
            stat_nxt[TT_LSB +: TT_W]    = TT_IEEE;
        end else if (unord) begin
            stat_nxt[INV_ACC]           = 1'b1;
        end
    end
endmodule

// File: rtl/fcmp_ccw.sv
module fcmp_ccw
    import fcmp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              is_double,
    input  logic              signaling,
    input  logic [1:0]        fcc_sel,
    input  logic [63:0]       op_a,
    input  logic [63:0]       op_b,
    input  logic [63:0]       stat_in,
    output logic [63:0]       stat_out,
    output logic              done,
    output logic              trap_req
);
    logic [OP_W-1:0] ops [2];
    fop_t            fops [2];
    rel_e            rel;
    logic [STAT_W-1:0] stat_nxt;
    logic            trap;

    assign ops[0] = op_a;
    assign ops[1] = op_b;

    for (genvar g = 0; g < 2; g++) begin : g_unpack
        fcmp_unpack u_unpack (
            .op        (ops[g]),
            .is_double (is_double),
            .fo        (fops[g])
        );
    end

    fcmp_relate u_relate (
        .a   (fops[0]),
        .b   (fops[1]),
        .rel (rel)
    );

    fcmp_stat_merge u_merge (
        .stat_in   (stat_in),
        .rel       (rel),
        .fcc_sel   (fcc_sel),
        .signaling (signaling),
        .stat_nxt  (stat_nxt),
        .trap      (trap)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_out <= '0;
            done     <= 1'b0;
            trap_req <= 1'b0;
        end else begin
            done     <= start;
            trap_req <= start && trap;
            if (start)
                stat_out <= stat_nxt;
        end
    end
endmodule

// File: rtl/fcmp_ccw_chk.sv
module fcmp_ccw_chk
    import fcmp_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic              signaling,
    input logic [1:0]        fcc_sel,
    input logic [63:0]       stat_in,
    input logic [63:0]       stat_out,
    input logic              done,
    input logic              trap_req
);
    logic [1:0]  sel_q;
    logic        sig_q;
    logic [63:0] touch;
    logic [1:0]  cur_field;
    int          lsb;

    always_ff @(posedge clk) begin
        sel_q <= fcc_sel;
        sig_q <= signaling;
    end

    assign lsb       = fcc_lsb(int'(sel_q));
    assign cur_field = stat_out[lsb +: 2];

    always_comb begin
        touch = '0;
        touch[lsb +: 2]          = 2'b11;
        touch[INV_CUR]           = 1'b1;
        touch[INV_ACC]           = 1'b1;
        touch[TT_LSB +: TT_W]    = '1;
    end

    assert_reset_R9: assert property (@(posedge clk)
        rst |=> (stat_out == '0 && !done && !trap_req));

    assert_done_follows_start_R8: assert property (@(posedge clk) disable iff (rst)
        start |=> done);

    assert_done_only_after_start_R8: assert property (@(posedge clk) disable iff (rst)
        !start |=> !done);

    assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(stat_out));

    assert_trap_with_done_R8: assert property (@(posedge clk) disable iff (rst)
        trap_req |-> done);

    assert_untouched_bits_R7: assert property (@(posedge clk) disable iff (rst)
        done |-> (((stat_out ^ $past(stat_in)) & ~touch) == '0));

    assert_ordered_no_flags_R7: assert property (@(posedge clk) disable iff (rst)
        (done && cur_field != 2'd3) |->
            (!trap_req && stat_out[INV_ACC] == $past(stat_in[INV_ACC])
                       && stat_out[INV_CUR] == $past(stat_in[INV_CUR])));

    assert_trap_code_R6: assert property (@(posedge clk) disable iff (rst)
        trap_req |-> (cur_field == 2'd3 && stat_out[TT_LSB +: TT_W] == TT_IEEE
                      && stat_out[INV_CUR]));

    assert_signaling_traps_R6: assert property (@(posedge clk) disable iff (rst)
        (done && sig_q && cur_field == 2'd3) |-> trap_req);

    assert_quiet_unordered_R5: assert property (@(posedge clk) disable iff (rst)
        (done && cur_field == 2'd3 && !trap_req) |-> stat_out[INV_ACC]);
endmodule

bind fcmp_ccw fcmp_ccw_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .signaling (signaling),
    .fcc_sel   (fcc_sel),
    .stat_in   (stat_in),
    .stat_out  (stat_out),
    .done      (done),
    .trap_req  (trap_req)
);

// File: tb/fcmp_ccw_tb.sv
`timescale 1ns/1ps
module fcmp_ccw_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic        is_double;
    logic        signaling;
    logic [1:0]  fcc_sel;
    logic [63:0] op_a;
    logic [63:0] op_b;
    logic [63:0] stat_in;
    logic [63:0] stat_out;
    logic        done;
    logic        trap_req;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    fcmp_ccw u_dut (
        .clk(clk), .rst(rst), .start(start), .is_double(is_double),
        .signaling(signaling), .fcc_sel(fcc_sel), .op_a(op_a), .op_b(op_b),
        .stat_in(stat_in), .stat_out(stat_out), .done(done), .trap_req(trap_req)
    );

    // Background status: bits 4, 9 and 27 cleared so writes to them show.
    localparam logic [63:0] BG = 64'hA5C3_5A3C_F30F_CDE5 & ~64'h0800_0210;

    // {dbl, sig, sel[1:0], ten, a[63:0], b[63:0], fcc[1:0], trap}
    localparam int NV = 19;
    localparam logic [135:0] VEC [NV] = '{
        {1'b0,1'b0,2'd0,1'b0, 64'h3F800000,           64'h40000000,           2'd1,1'b0}, // R1 R2 lt
        {1'b0,1'b0,2'd1,1'b0, 64'h40000000,           64'h3F800000,           2'd2,1'b0}, // R2 gt
        {1'b0,1'b0,2'd2,1'b0, 64'h00000000,           64'h80000000,           2'd0,1'b0}, // R3 zeros
        {1'b0,1'b0,2'd3,1'b0, 64'hBF800000,           64'h3F800000,           2'd1,1'b0}, // R2 sign
        {1'b0,1'b0,2'd0,1'b0, 64'hC0000000,           64'hBF800000,           2'd1,1'b0}, // R1 negatives
        {1'b0,1'b0,2'd0,1'b0, 64'h7F800000,           64'h40000000,           2'd2,1'b0}, // R3 inf
        {1'b0,1'b0,2'd1,1'b0, 64'h7FC00000,           64'h3F800000,           2'd3,1'b0}, // R5
        {1'b0,1'b0,2'd2,1'b1, 64'h3F800000,           64'h7FC00000,           2'd3,1'b1}, // R6 enable
        {1'b0,1'b1,2'd3,1'b0, 64'h7FA00000,           64'h3F800000,           2'd3,1'b1}, // R6 signaling
        {1'b0,1'b1,2'd0,1'b0, 64'h3F800000,           64'h3F800000,           2'd0,1'b0}, // R7 sig ordered
        {1'b1,1'b0,2'd1,1'b0, 64'h3FF0000000000000,   64'h4000000000000000,   2'd1,1'b0}, // R1 dbl
        {1'b1,1'b0,2'd2,1'b0, 64'hC000000000000000,   64'h3FF0000000000000,   2'd1,1'b0}, // R1 dbl sign
        {1'b1,1'b0,2'd3,1'b0, 64'h7FF0000000000000,   64'h4000000000000000,   2'd2,1'b0}, // R3 dbl inf
        {1'b1,1'b0,2'd0,1'b0, 64'h8000000000000000,   64'h0000000000000000,   2'd0,1'b0}, // R3 dbl zeros
        {1'b1,1'b0,2'd1,1'b0, 64'h7FF8000000000000,   64'h3FF0000000000000,   2'd3,1'b0}, // R5 dbl
        {1'b1,1'b1,2'd0,1'b0, 64'h7FF8000000000000,   64'h3FF0000000000000,   2'd3,1'b1}, // R6 dbl sig
        {1'b0,1'b0,2'd2,1'b0, 64'hFFFFFFFF3F800000,   64'h7FF8000040000000,   2'd1,1'b0}, // R4 upper junk
        {1'b1,1'b0,2'd3,1'b0, 64'h7FF0000000000000,   64'h7FF0000000000000,   2'd0,1'b0}, // R3 inf eq
        {1'b1,1'b1,2'd1,1'b1, 64'h3FF0000000000000,   64'h3FF0000000000000,   2'd0,1'b0}  // R7 ten set ordered
    };

    function automatic int pos_of(input logic [1:0] s);
        case (s)
            2'd0: return 10;
            2'd1: return 32;
            2'd2: return 34;
            default: return 36;
        endcase
    endfunction

    function automatic logic [63:0] expect_stat(input logic [63:0] si, input logic [1:0] s,
                                                input logic [1:0] code, input logic tr);
        logic [63:0] r;
        r = si;
        r[pos_of(s) +: 2] = code;
        if (tr) begin
            r[4] = 1'b1;
            r[16:14] = 3'd1;
        end else if (code == 2'd3) begin
            r[9] = 1'b1;
        end
        return r;
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic run_one(input logic [135:0] v, input string tag);
        logic [63:0] si;
        @(negedge clk);
        is_double = v[135];
        signaling = v[134];
        fcc_sel   = v[133:132];
        op_a      = v[130:67];
        op_b      = v[66:3];
        si        = BG | (64'(v[131]) << 27);
        stat_in   = si;
        start     = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check({tag, " stat"}, stat_out, expect_stat(si, v[133:132], v[2:1], v[0]));
        check({tag, " done R8"}, 64'(done), 64'd1);
        check({tag, " trap R6"}, 64'(trap_req), 64'(v[0]));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [63:0] held;
        rst = 1'b1; start = 1'b0; is_double = 1'b0; signaling = 1'b0;
        fcc_sel = '0; op_a = '0; op_b = '0; stat_in = '1;
        repeat (3) @(negedge clk);
        check("R9 stat_out", stat_out, 64'd0);
        check("R9 done", 64'(done), 64'd0);
        check("R9 trap", 64'(trap_req), 64'd0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++)
            run_one(VEC[i], $sformatf("vec%0d R1", i));

        // R8: done is a single pulse and stat_out holds without start.
        held = stat_out;
        @(negedge clk);
        check("R8 done pulse", 64'(done), 64'd0);
        stat_in = ~BG;
        op_a = 64'h7FC00000;
        @(negedge clk);
        check("R8 hold", stat_out, held);
        check("R8 no trap idle", 64'(trap_req), 64'd0);

        // R8: back-to-back starts, each result one cycle later.
        stat_in = BG; is_double = 1'b0; signaling = 1'b0; fcc_sel = 2'd3;
        op_a = 64'h40000000; op_b = 64'h3F800000; start = 1'b1;
        @(negedge clk);
        check("R8 b2b first", stat_out, expect_stat(BG, 2'd3, 2'd2, 1'b0));
        fcc_sel = 2'd0; op_a = 64'h3F800000; op_b = 64'h40000000;
        @(negedge clk);
        start = 1'b0;
        check("R8 b2b second", stat_out, expect_stat(BG, 2'd0, 2'd1, 1'b0));
        check("R8 b2b done", 64'(done), 64'd1);

        // R9: reset mid-stream clears the output.
        rst = 1'b1;
        @(negedge clk);
        check("R9 re-reset", stat_out, 64'd0);
        rst = 1'b0;

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule